// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block keeps a small fully associative record of loads that a processor issued early, ahead of stores whose addresses were not known to be disjoint from the load. Each early load claims an entry. The entry holds the destination register number, whether that register is integer or floating-point, and the byte range the load read. Every store presents its byte range. Any recorded range that the store touches is dropped.

A later check names a register and its class. If a live entry matches, the early value is still good. If not, the block reports that the pipeline must act. A reload-style check asks for the value to be fetched again. A branch-style check, used when dependent work was also hoisted, asks for a jump to recovery code. The block does no memory access and no recovery of its own. Floating-point pair loads are floating-point class entries with a 16-byte range.

A single-cycle flush empties the table on a context switch. When the table is full, a rotating pointer picks the entry to overwrite. A check that later misses because of such an overwrite only costs a needless recovery; it never produces a wrong result.

Top module: `spec_load_table`

## Requirements
- R1: After reset every entry is invalid, so any check misses. The three check outputs are low in every cycle where `chk_valid` is low.
- R2: An early load (`ld_valid`) records an entry. From the next cycle, a check with the same register number and class reports `chk_hit` in the same cycle it is presented.
- R3: The class is part of the match, with `0` meaning integer and `1` meaning floating-point. A check of one class never hits an entry of the other class.
- R4: On a miss, `chk_branch`=0 (reload style) raises `chk_reload` and `chk_branch`=1 (branch style) raises `chk_recover`. On a hit, neither is raised. At most one of `chk_hit`, `chk_reload` and `chk_recover` is high.
- R5: A check with `chk_clear` set removes the matching entry from the next cycle, whether the lookup hit or missed. A clearing check that finds nothing leaves the other entries untouched.
- R6: A store covering bytes [st_addr, st_addr+st_size) invalidates every entry whose range [addr, addr+size) shares at least one byte with it. Adjacent ranges that share no byte are unaffected, and a size of zero covers no bytes.
- R7: An early load to a register and class that already have an entry overwrites that entry. No duplicate is created, and the old address range is no longer watched.
- R8: A new entry goes to the lowest-numbered free slot. When every slot is valid, it goes to the slot named by a rotating pointer. The pointer starts at 0 after reset and moves to the next slot, wrapping around, only on such an eviction.
- R9: When a store and a check arrive in the same cycle and the store overlaps the entry the check would match, the check reports a miss.
- R10: `inv_all` makes every entry invalid from the next cycle, including an entry being written in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Early load presented this cycle |
| ld_reg | input | REG_W | Destination register number of the early load |
| ld_fp | input | 1 | Class of the early load: 0 integer, 1 floating-point |
| ld_addr | input | ADDR_W | First byte address read by the early load |
| ld_size | input | SIZE_W | Bytes read by the early load |
| st_valid | input | 1 | Store presented this cycle |
| st_addr | input | ADDR_W | First byte address written by the store |
| st_size | input | SIZE_W | Bytes written by the store |
| chk_valid | input | 1 | Check presented this cycle |
| chk_reg | input | REG_W | Register number being checked |
| chk_fp | input | 1 | Class being checked: 0 integer, 1 floating-point |
| chk_branch | input | 1 | Check style: 0 reload, 1 branch to recovery |
| chk_clear | input | 1 | Remove the matching entry after the lookup |
| inv_all | input | 1 | Invalidate every entry |
| chk_hit | output | 1 | Check found a live matching entry (combinational) |
| chk_reload | output | 1 | Reload-style check missed (combinational) |
| chk_recover | output | 1 | Branch-style check missed (combinational) |

## Verification
The embedded properties assume that a store, an early load and a check may all come in one cycle. They also assume that `ld_addr + ld_size` and `st_addr + st_size` are computed one bit wider than the address, so ranges at the top of the space do not wrap. The duplicate-free property relies on every write going through the allocator, which always reuses a matching slot. The stimulus keeps every address far from the top of the space. It combines same-cycle store and check only in the directed cases written for R9, so that each other check sees one cause at a time.

// File: rtl/slt_pkg.sv
package slt_pkg;

    // Register class of a tracked load
    typedef enum logic {
        CLS_INT = 1'b0,
        CLS_FP  = 1'b1
    } reg_cls_e;

    // Outcome style requested by a check
    typedef enum logic {
        STYLE_RELOAD = 1'b0,
        STYLE_BRANCH = 1'b1
    } chk_style_e;

    // Widest slot vector the allocator helper handles
    localparam int unsigned MAX_SLOTS = 64;

    // Index of the lowest set bit, 0 when none is set
    function automatic int unsigned lowest_set(input logic [MAX_SLOTS-1:0] vec);
        int unsigned idx;
        idx = 0;
        for (int i = MAX_SLOTS - 1; i >= 0; i--) begin
            if (vec[i]) idx = i;
        end
        return idx;
    endfunction

endpackage

// File: rtl/slt_entry.sv
module slt_entry
    import slt_pkg::*;
#(
    parameter int REG_W  = 7,
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              alloc,
    input  logic [REG_W-1:0]  new_reg,
    input  reg_cls_e          new_cls,
    input  logic [ADDR_W-1:0] new_addr,
    input  logic [SIZE_W-1:0] new_size,
    input  logic              kill,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SIZE_W-1:0] st_size,
    input  logic [REG_W-1:0]  chk_reg,
    input  reg_cls_e          chk_cls,
    input  logic [REG_W-1:0]  ld_reg,
    input  reg_cls_e          ld_cls,
    output logic              vld,
    output logic              chk_match,
    output logic              ld_match,
    output logic              snoop_hit
);

    typedef struct packed {
        logic [REG_W-1:0]  rnum;
        reg_cls_e          cls;
        logic [ADDR_W-1:0] base;
        logic [SIZE_W-1:0] len;
    } tag_t;

    tag_t             tag_q;
    logic             vld_q;
    logic [ADDR_W:0]  ent_lo, ent_hi, st_lo, st_hi;

    // Range ends are one bit wider so the sum never wraps
    always_comb begin
        ent_lo = {1'b0, tag_q.base};
        ent_hi = {1'b0, tag_q.base} + (ADDR_W+1)'(tag_q.len);
        st_lo  = {1'b0, st_addr};
        st_hi  = {1'b0, st_addr} + (ADDR_W+1)'(st_size);
    end

    assign snoop_hit = vld_q && st_valid && (st_size != '0) && (tag_q.len != '0)
                       && (st_lo < ent_hi) && (ent_lo < st_hi);
    assign chk_match = vld_q && (tag_q.rnum == chk_reg) && (tag_q.cls == chk_cls);
    assign ld_match  = vld_q && (tag_q.rnum == ld_reg) && (tag_q.cls == ld_cls);
    assign vld       = vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            tag_q <= '0;
        end else begin
            if (alloc) begin
                tag_q.rnum <= new_reg;
                tag_q.cls  <= new_cls;
                tag_q.base <= new_addr;
                tag_q.len  <= new_size;
            end
            if (flush)
                vld_q <= 1'b0;
            else if (alloc)
                vld_q <= 1'b1;
            else if (snoop_hit || kill)
                vld_q <= 1'b0;
        end
    end

    // R2
    alloc_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc && !flush) |=> vld_q);

    // R6
    snoop_drops_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (snoop_hit && !alloc) |=> !vld_q);

endmodule

// File: rtl/slt_alloc.sv
module slt_alloc
    import slt_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_valid,
    input  logic [ENTRIES-1:0] vld,
    input  logic [ENTRIES-1:0] same,
    output logic [ENTRIES-1:0] way_sel
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] pick;
    logic             any_same, full, evict;

    always_comb begin
        any_same = |same;
        full     = &vld;
        evict    = ld_valid && !any_same && full;
        if (any_same)
            pick = IDX_W'(lowest_set(MAX_SLOTS'(same)));
        else if (!full)
            pick = IDX_W'(lowest_set(MAX_SLOTS'(~vld)));
        else
            pick = rr_q;
        way_sel = '0;
        way_sel[pick] = ld_valid;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rr_q <= '0;
        else if (evict)
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end

    // R8
    victim_is_pointer_chk: assert property (@(posedge clk) disable iff (rst)
        evict |-> (way_sel[rr_q] && $onehot(way_sel)));

    // R7
    reuse_own_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && any_same) |-> ((way_sel & ~same) == '0));

endmodule

// File: rtl/spec_load_table.sv
module spec_load_table
    import slt_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int REG_W   = 7,
    parameter int ADDR_W  = 32,
    parameter int SIZE_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [REG_W-1:0]  ld_reg,
    input  logic              ld_fp,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SIZE_W-1:0] ld_size,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SIZE_W-1:0] st_size,
    input  logic              chk_valid,
    input  logic [REG_W-1:0]  chk_reg,
    input  logic              chk_fp,
    input  logic              chk_branch,
    input  logic              chk_clear,
    input  logic              inv_all,
    output logic              chk_hit,
    output logic              chk_reload,
    output logic              chk_recover
);

    reg_cls_e   ld_cls, chk_cls;
    chk_style_e style;

    logic [ENTRIES-1:0] vld_v, chkm_v, ldm_v, snp_v, way_sel, kill_v, live_v;
    logic               dup_free;

    assign ld_cls  = reg_cls_e'(ld_fp);
    assign chk_cls = reg_cls_e'(chk_fp);
    assign style   = chk_style_e'(chk_branch);

    slt_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .clk      (clk),
        .rst      (rst),
        .ld_valid (ld_valid),
        .vld      (vld_v),
        .same     (ldm_v),
        .way_sel  (way_sel)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        slt_entry #(
            .REG_W  (REG_W),
            .ADDR_W (ADDR_W),
            .SIZE_W (SIZE_W)
        ) u_ent (
            .clk       (clk),
            .rst       (rst),
            .flush     (inv_all),
            .alloc     (way_sel[g]),
            .new_reg   (ld_reg),
            .new_cls   (ld_cls),
            .new_addr  (ld_addr),
            .new_size  (ld_size),
            .kill      (kill_v[g]),
            .st_valid  (st_valid),
            .st_addr   (st_addr),
            .st_size   (st_size),
            .chk_reg   (chk_reg),
            .chk_cls   (chk_cls),
            .ld_reg    (ld_reg),
            .ld_cls    (ld_cls),
            .vld       (vld_v[g]),
            .chk_match (chkm_v[g]),
            .ld_match  (ldm_v[g]),
            .snoop_hit (snp_v[g])
        );
    end

    // A same-cycle overlapping store beats the lookup
    always_comb begin
        kill_v      = chk_valid && chk_clear ? chkm_v : '0;
        live_v      = chkm_v & ~snp_v;
        chk_hit     = chk_valid && (live_v != '0);
        chk_reload  = chk_valid && !chk_hit && (style == STYLE_RELOAD);
        chk_recover = chk_valid && !chk_hit && (style == STYLE_BRANCH);
    end

    // Independent scan for two live entries with the same key
    always_comb begin
        dup_free = 1'b1;
        for (int i = 0; i < ENTRIES; i++) begin
            for (int j = i + 1; j < ENTRIES; j++) begin
                if (vld_v[i] && vld_v[j]
                    && g_slot_key(i) == g_slot_key(j))
                    dup_free = 1'b0;
            end
        end
    end

    function automatic logic [REG_W:0] g_slot_key(input int k);
        logic [REG_W:0] key;
        key = '0;
        for (int s = 0; s < ENTRIES; s++) begin
            if (s == k) key = {g_key[s]};
        end
        return key;
    endfunction

    logic [REG_W:0] g_key [ENTRIES];
    for (genvar g = 0; g < ENTRIES; g++) begin : g_keys
        assign g_key[g] = {g_slot[g].u_ent.tag_q.rnum, logic'(g_slot[g].u_ent.tag_q.cls)};
    end

    // R4
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({chk_hit, chk_reload, chk_recover}));

    // R1
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |-> !(chk_hit || chk_reload || chk_recover));

    // R10
    flush_all_chk: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> (vld_v == '0));

    // R5
    clear_removes_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && chk_clear && !ld_valid) |=> ((vld_v & $past(chkm_v)) == '0));

    // R7
    no_duplicate_chk: assert property (@(posedge clk) disable iff (rst)
        dup_free);

endmodule

// File: tb/spec_load_table_test.sv
module spec_load_table_test;

    localparam int REG_W  = 7;
    localparam int ADDR_W = 32;
    localparam int SIZE_W = 5;

    localparam logic [1:0] OP_LD  = 2'd0;
    localparam logic [1:0] OP_ST  = 2'd1;
    localparam logic [1:0] OP_CHK = 2'd2;
    localparam logic [1:0] OP_INV = 2'd3;

    // expected bits: {hit, reload, recover}
    localparam logic [2:0] E_HIT = 3'b100;
    localparam logic [2:0] E_REL = 3'b010;
    localparam logic [2:0] E_REC = 3'b001;
    localparam logic [2:0] E_NON = 3'b000;

    typedef struct packed {
        logic [1:0]  op;
        logic [6:0]  rg;
        logic        fp;
        logic [31:0] addr;
        logic [4:0]  size;
        logic        br;
        logic        cl;
        logic [2:0]  ex;
        logic [7:0]  rq;
    } vec_t;

    function automatic vec_t mk(input logic [1:0] op, input logic [6:0] rg, input logic fp,
                                input logic [31:0] addr, input logic [4:0] size,
                                input logic br, input logic cl, input logic [2:0] ex,
                                input logic [7:0] rq);
        vec_t v;
        v.op = op; v.rg = rg; v.fp = fp; v.addr = addr; v.size = size;
        v.br = br; v.cl = cl; v.ex = ex; v.rq = rq;
        return v;
    endfunction

    localparam int NV = 24;
    localparam vec_t TBL [NV] = '{
        mk(OP_LD,  7'd5, 1'b0, 32'h100, 5'd8,  1'b0, 1'b0, E_NON, 8'd2),
        mk(OP_CHK, 7'd5, 1'b0, 32'h0,   5'd0,  1'b0, 1'b0, E_HIT, 8'd2),  // R2 hit
        mk(OP_CHK, 7'd5, 1'b1, 32'h0,   5'd0,  1'b0, 1'b0, E_REL, 8'd3),  // R3 fp vs int
        mk(OP_ST,  7'd0, 1'b0, 32'h108, 5'd8,  1'b0, 1'b0, E_NON, 8'd6),
        mk(OP_CHK, 7'd5, 1'b0, 32'h0,   5'd0,  1'b1, 1'b0, E_HIT, 8'd6),  // R6 above, adjacent
        mk(OP_ST,  7'd0, 1'b0, 32'h0F8, 5'd8,  1'b0, 1'b0, E_NON, 8'd6),
        mk(OP_CHK, 7'd5, 1'b0, 32'h0,   5'd0,  1'b1, 1'b0, E_HIT, 8'd6),  // R6 below, adjacent
        mk(OP_ST,  7'd0, 1'b0, 32'h107, 5'd1,  1'b0, 1'b0, E_NON, 8'd6),
        mk(OP_CHK, 7'd5, 1'b0, 32'h0,   5'd0,  1'b1, 1'b0, E_REC, 8'd4),  // R4 branch miss
        mk(OP_LD,  7'd6, 1'b1, 32'h200, 5'd16, 1'b0, 1'b0, E_NON, 8'd2),
        mk(OP_CHK, 7'd6, 1'b0, 32'h0,   5'd0,  1'b0, 1'b0, E_REL, 8'd3),  // R3 int vs fp
        mk(OP_CHK, 7'd6, 1'b1, 32'h0,   5'd0,  1'b0, 1'b1, E_HIT, 8'd5),  // R5 hit+clear
        mk(OP_CHK, 7'd6, 1'b1, 32'h0,   5'd0,  1'b0, 1'b0, E_REL, 8'd5),  // R5 gone
        mk(OP_LD,  7'd7, 1'b0, 32'h300, 5'd4,  1'b0, 1'b0, E_NON, 8'd7),
        mk(OP_LD,  7'd7, 1'b0, 32'h400, 5'd4,  1'b0, 1'b0, E_NON, 8'd7),
        mk(OP_ST,  7'd0, 1'b0, 32'h300, 5'd4,  1'b0, 1'b0, E_NON, 8'd7),
        mk(OP_CHK, 7'd7, 1'b0, 32'h0,   5'd0,  1'b1, 1'b0, E_HIT, 8'd7),  // R7 old range ignored
        mk(OP_ST,  7'd0, 1'b0, 32'h403, 5'd1,  1'b0, 1'b0, E_NON, 8'd7),
        mk(OP_CHK, 7'd7, 1'b0, 32'h0,   5'd0,  1'b0, 1'b0, E_REL, 8'd7),  // R7 new range watched
        mk(OP_LD,  7'd8, 1'b0, 32'h500, 5'd4,  1'b0, 1'b0, E_NON, 8'd5),
        mk(OP_CHK, 7'd9, 1'b0, 32'h0,   5'd0,  1'b0, 1'b1, E_REL, 8'd5),  // R5 clearing miss
        mk(OP_CHK, 7'd8, 1'b0, 32'h0,   5'd0,  1'b0, 1'b0, E_HIT, 8'd5),  // R5 others kept
        mk(OP_INV, 7'd0, 1'b0, 32'h0,   5'd0,  1'b0, 1'b0, E_NON, 8'd10),
        mk(OP_CHK, 7'd8, 1'b0, 32'h0,   5'd0,  1'b1, 1'b0, E_REC, 8'd10)  // R10 flushed
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ld_valid = 1'b0;
    logic [REG_W-1:0]  ld_reg = '0;
    logic              ld_fp = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [SIZE_W-1:0] ld_size = '0;
    logic              st_valid = 1'b0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic [SIZE_W-1:0] st_size = '0;
    logic              chk_valid = 1'b0;
    logic [REG_W-1:0]  chk_reg = '0;
    logic              chk_fp = 1'b0;
    logic              chk_branch = 1'b0;
    logic              chk_clear = 1'b0;
    logic              inv_all = 1'b0;
    logic              chk_hit, chk_reload, chk_recover;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    spec_load_table #(
        .ENTRIES (4),
        .REG_W   (REG_W),
        .ADDR_W  (ADDR_W),
        .SIZE_W  (SIZE_W)
    ) uut (
        .clk (clk), .rst (rst),
        .ld_valid (ld_valid), .ld_reg (ld_reg), .ld_fp (ld_fp),
        .ld_addr (ld_addr), .ld_size (ld_size),
        .st_valid (st_valid), .st_addr (st_addr), .st_size (st_size),
        .chk_valid (chk_valid), .chk_reg (chk_reg), .chk_fp (chk_fp),
        .chk_branch (chk_branch), .chk_clear (chk_clear),
        .inv_all (inv_all),
        .chk_hit (chk_hit), .chk_reload (chk_reload), .chk_recover (chk_recover)
    );

    task automatic compare(input string rq, input logic [2:0] ex);
        logic [2:0] got;
        got = {chk_hit, chk_reload, chk_recover};
        checks++;
        if (got !== ex) begin
            fails++;
            $display("FAIL %s: {hit,reload,recover} actual %b expected %b", rq, got, ex);
        end
    endtask

    task automatic release_all();
        @(posedge clk);
        #1;
        ld_valid = 1'b0; st_valid = 1'b0; chk_valid = 1'b0;
        chk_clear = 1'b0; inv_all = 1'b0;
    endtask

    task automatic do_ld(input logic [6:0] r, input logic fp, input logic [31:0] a,
                         input logic [4:0] s);
        @(negedge clk);
        ld_valid = 1'b1; ld_reg = r; ld_fp = fp; ld_addr = a; ld_size = s;
        release_all();
    endtask

    task automatic do_st(input logic [31:0] a, input logic [4:0] s);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_size = s;
        release_all();
    endtask

    task automatic do_inv();
        @(negedge clk);
        inv_all = 1'b1;
        release_all();
    endtask

    task automatic do_chk(input logic [6:0] r, input logic fp, input logic br,
                          input logic cl, input logic [2:0] ex, input string rq);
        @(negedge clk);
        chk_valid = 1'b1; chk_reg = r; chk_fp = fp; chk_branch = br; chk_clear = cl;
        #2;
        compare(rq, ex);
        release_all();
    endtask

    // store and check together in one cycle
    task automatic do_st_chk(input logic [31:0] a, input logic [4:0] s,
                             input logic [6:0] r, input logic [2:0] ex, input string rq);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_size = s;
        chk_valid = 1'b1; chk_reg = r; chk_fp = 1'b0; chk_branch = 1'b0; chk_clear = 1'b0;
        #2;
        compare(rq, ex);
        release_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: idle outputs low, then empty table misses
        @(negedge clk);
        #2 compare("R1 idle", E_NON);
        do_chk(7'd5, 1'b0, 1'b0, 1'b0, E_REL, "R1 empty");

        for (int i = 0; i < NV; i++) begin
            case (TBL[i].op)
                OP_LD:  do_ld(TBL[i].rg, TBL[i].fp, TBL[i].addr, TBL[i].size);
                OP_ST:  do_st(TBL[i].addr, TBL[i].size);
                OP_INV: do_inv();
                default: do_chk(TBL[i].rg, TBL[i].fp, TBL[i].br, TBL[i].cl, TBL[i].ex,
                                $sformatf("R%0d step %0d", TBL[i].rq, i));
            endcase
        end

        // R8: fill free slots in order, then rotate the victim
        for (int k = 0; k < 4; k++)
            do_ld(7'(k + 1), 1'b0, 32'h1000 + 32'(k * 16), 5'd8);
        do_ld(7'd10, 1'b0, 32'h2000, 5'd8);
        do_chk(7'd1,  1'b0, 1'b0, 1'b0, E_REL, "R8 first victim");
        do_chk(7'd2,  1'b0, 1'b0, 1'b0, E_HIT, "R8 survivor");
        do_chk(7'd10, 1'b0, 1'b0, 1'b0, E_HIT, "R8 newcomer");
        do_ld(7'd11, 1'b0, 32'h2100, 5'd8);
        do_chk(7'd2,  1'b0, 1'b1, 1'b0, E_REC, "R8 second victim");
        do_chk(7'd3,  1'b0, 1'b0, 1'b0, E_HIT, "R8 survivor");

        // R9: store overlapping the checked entry in the same cycle
        do_inv();
        do_ld(7'd20, 1'b0, 32'h600, 5'd8);
        do_st_chk(32'h604, 5'd2, 7'd20, E_REL, "R9 same cycle");
        do_chk(7'd20, 1'b0, 1'b0, 1'b0, E_REL, "R9 after");
        do_ld(7'd21, 1'b0, 32'h700, 5'd8);
        do_st_chk(32'h800, 5'd4, 7'd21, E_HIT, "R9 disjoint store");

        // R6: zero-size store touches nothing
        do_st(32'h702, 5'd0);
        do_chk(7'd21, 1'b0, 1'b0, 1'b0, E_HIT, "R6 zero size");

        finish_run();
    end

endmodule